// File: doc/BRIEF.md
# Interrupt Target Router with Pending Migration

This block holds the routing state of a small interrupt distributor. Each interrupt has a byte-wide CPU target field, and each CPU has its own pending bit for each interrupt. Software reads and writes the target fields over a simple register bus. A separate request port raises or drops the pending state of one interrupt at a time. The block presents one pending vector per CPU to the logic that arbitrates and signals the processors.

The key property is consistency under retargeting. If software rewrites the target field of a shared interrupt while that interrupt is pending anywhere, the pending state follows the new field on the same clock edge. CPUs that gain the interrupt see it pending. CPUs that lose it no longer see it. Interrupts numbered below 32 are private to each CPU. Their routing is fixed to every CPU, and their target fields cannot be written.

The block takes the interrupt count and the CPU count (1 to 8) as parameters. CPU `c`'s pending vector occupies bits `[c*NUM_IRQ +: NUM_IRQ]` of `cpuPending`, with bit `i` for interrupt `i`.

Top module: `dist_target_router`

## Requirements
- R1: After reset, every pending bit is 0 and every shared target field reads as 0. `regRdData` reads 0 in any cycle that follows no read access.
- R2: Target field `n` sits at address `0x800 + n`. A write to a shared field (n >= 32, n < NUM_IRQ) stores the data ANDed with the existing-CPU mask (bit c = CPU c). A read returns the stored byte on `regRdData` in the cycle after the access.
- R3: Any read or write whose address lies below `0x800`, or whose interrupt number is NUM_IRQ or more, is an error. It changes no state, `regErr` is 1 for exactly the cycle after the access, and `regRdData` is 0 in that cycle.
- R4: For interrupts below 32 with more than one CPU, writes are ignored and reads return the all-CPUs mask.
- R5: With NUM_CPU = 1, every target field reads 0 and writes are ignored. Every interrupt is routed to CPU 0.
- R6: A set request for a shared interrupt makes it pending on exactly the CPUs in its current target field. A set request for an internal interrupt makes it pending on all CPUs. The result is visible after the next clock edge.
- R7: A clear request drops the interrupt's pending bit on every CPU. If set and clear are requested together, clear wins.
- R8: Writing the target field of a shared interrupt that is pending on any CPU replaces its pending set with the new field at the same clock edge. Added CPUs become pending and removed CPUs stop being pending.
- R9: Writing the target field of an interrupt that is not pending leaves all pending bits unchanged.
- R10: A set request and a target write for the same interrupt in the same cycle route the set by the newly written field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte address of the access |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Read data, valid the cycle after a read |
| regErr | output | 1 | One-cycle error pulse for a bad access |
| pendSet | input | 1 | Request to make `pendIrq` pending |
| pendClr | input | 1 | Request to drop `pendIrq` pending |
| pendIrq | input | PIRQ_W | Interrupt number of the request |
| cpuPending | output | NUM_CPU*NUM_IRQ | Per-CPU pending vectors |

## Verification
The assertions check four things on every cycle:
- every error pulse follows an access and carries zero read data;
- read data never shows bits of CPUs that do not exist;
- internal fields read back as all-CPUs;
- a clear request empties the interrupt on every CPU, and no pending bit rises without a set request or a target write in the cycle before.

Only the bench scenarios can show that retargeting moves pending state to exactly the new CPU set, that an unpending interrupt is left alone, that a same-cycle write steers a set request, and that a single-CPU build reads zero while routing everything to CPU 0.

// File: rtl/dist_route_pkg.sv
package dist_route_pkg;
  localparam int IDX_W        = 10;   // interrupt index width inside the strobe struct
  localparam int MASK_W       = 8;    // target field width
  localparam int INTERNAL_CNT = 32;   // interrupts below this are per-CPU private
  localparam int TARGET_BASE  = 2048; // byte address of target field 0

  typedef struct packed {
    logic              wrStb;   // accepted write to a shared target field
    logic              rdStb;   // in-range read
    logic              errStb;  // bad access
    logic [IDX_W-1:0]  regIdx;  // interrupt number addressed by the bus
    logic [MASK_W-1:0] wrMask;  // write data already masked to existing CPUs
    logic              setStb;  // set-pending request (clear not active)
    logic              clrStb;  // clear-pending request
    logic [IDX_W-1:0]  pendIdx; // interrupt number of the request
  } dist_strobe_t;
endpackage

// File: rtl/dist_route_ctrl.sv
module dist_route_ctrl
  import dist_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int PIRQ_W  = 6
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              pendSet,
  input  logic              pendClr,
  input  logic [PIRQ_W-1:0] pendIrq,
  output dist_strobe_t      strobes
);
  localparam logic [ADDR_W-1:0] BASE      = ADDR_W'(TARGET_BASE);
  localparam logic [ADDR_W-1:0] LIMIT     = ADDR_W'(NUM_IRQ);
  localparam logic [MASK_W-1:0] CPU_MASK  = MASK_W'((1 << NUM_CPU) - 1);
  localparam bit                MULTI_CPU = (NUM_CPU > 1);

  logic [ADDR_W-1:0] offs;
  logic              inWindow;
  logic              isShared;
  logic              pendOk;
  logic [IDX_W-1:0]  idx;

  assign offs     = regAddr - BASE;
  assign inWindow = (regAddr >= BASE) && (offs < LIMIT);
  assign idx      = IDX_W'(offs);
  assign isShared = (idx >= IDX_W'(INTERNAL_CNT));
  assign pendOk   = (32'(pendIrq) < NUM_IRQ);

  always_comb begin
    strobes         = '0;
    strobes.wrStb   = regWrEn && inWindow && MULTI_CPU && isShared;
    strobes.rdStb   = regRdEn && inWindow;
    strobes.errStb  = (regWrEn || regRdEn) && !inWindow;
    strobes.regIdx  = idx;
    strobes.wrMask  = regWrData & CPU_MASK;
    strobes.clrStb  = pendClr && pendOk;
    strobes.setStb  = pendSet && pendOk && !pendClr;
    strobes.pendIdx = IDX_W'(pendIrq);
  end
endmodule

// File: rtl/dist_route_datapath.sv
module dist_route_datapath
  import dist_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dist_strobe_t               strobes,
  output logic [7:0]                 regRdData,
  output logic                       regErr,
  output logic [NUM_CPU*NUM_IRQ-1:0] cpuPending
);
  localparam logic [NUM_CPU-1:0] ALL_CPUS = '1;

  logic [NUM_CPU-1:0] tgtQ [NUM_IRQ];
  logic [NUM_CPU-1:0] rdVal;
  logic               unusedMaskBits;

  assign unusedMaskBits = ^strobes.wrMask;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [NUM_CPU-1:0] tgtReg;
    logic [NUM_CPU-1:0] routeMask;
    logic [NUM_CPU-1:0] pendReg;
    logic               wrHere;
    logic               setHere;
    logic               clrHere;

    assign setHere = strobes.setStb && (strobes.pendIdx == IDX_W'(i));
    assign clrHere = strobes.clrStb && (strobes.pendIdx == IDX_W'(i));

    if (i < INTERNAL_CNT || NUM_CPU == 1) begin : g_fixed
      assign wrHere    = 1'b0;
      assign tgtReg    = (NUM_CPU == 1) ? '0 : ALL_CPUS;
      assign routeMask = ALL_CPUS;
    end else begin : g_shared
      assign wrHere = strobes.wrStb && (strobes.regIdx == IDX_W'(i));
      always_ff @(posedge clk) begin
        if (rst)         tgtReg <= '0;
        else if (wrHere) tgtReg <= strobes.wrMask[NUM_CPU-1:0];
      end
      assign routeMask = wrHere ? strobes.wrMask[NUM_CPU-1:0] : tgtReg;
    end

    always_ff @(posedge clk) begin
      if (rst)                      pendReg <= '0;
      else if (clrHere)             pendReg <= '0;
      else if (setHere)             pendReg <= routeMask;
      else if (wrHere && |pendReg)  pendReg <= routeMask;
    end

    assign tgtQ[i] = tgtReg;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      assign cpuPending[c*NUM_IRQ + i] = pendReg[c];
    end
  end

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (strobes.regIdx == IDX_W'(i)) rdVal = tgtQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regRdData <= '0;
      regErr    <= 1'b0;
    end else begin
      regRdData <= strobes.rdStb ? 8'(rdVal) : 8'h00;
      regErr    <= strobes.errStb;
    end
  end
endmodule

// File: rtl/dist_target_router.sv
module dist_target_router
  import dist_route_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int PIRQ_W  = $clog2(NUM_IRQ)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       regWrEn,
  input  logic                       regRdEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [7:0]                 regWrData,
  output logic [7:0]                 regRdData,
  output logic                       regErr,
  input  logic                       pendSet,
  input  logic                       pendClr,
  input  logic [PIRQ_W-1:0]          pendIrq,
  output logic [NUM_CPU*NUM_IRQ-1:0] cpuPending
);
  dist_strobe_t strobes;

  dist_route_ctrl #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .PIRQ_W(PIRQ_W)
  ) u_ctrl (
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .pendSet  (pendSet),
    .pendClr  (pendClr),
    .pendIrq  (pendIrq),
    .strobes  (strobes)
  );

  dist_route_datapath #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .regRdData (regRdData),
    .regErr    (regErr),
    .cpuPending(cpuPending)
  );
endmodule

// File: rtl/dist_target_router_chk.sv
module dist_target_router_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int PIRQ_W  = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       regWrEn,
  input logic                       regRdEn,
  input logic [ADDR_W-1:0]          regAddr,
  input logic [7:0]                 regRdData,
  input logic                       regErr,
  input logic                       pendSet,
  input logic                       pendClr,
  input logic [PIRQ_W-1:0]          pendIrq,
  input logic [NUM_CPU*NUM_IRQ-1:0] cpuPending
);
  localparam int W = NUM_CPU * NUM_IRQ;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(2048);
  localparam logic [7:0] ALL8 = 8'((1 << NUM_CPU) - 1);

  function automatic logic [W-1:0] colMask(input logic [PIRQ_W-1:0] idx);
    logic [W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CPU; c++) m[c*NUM_IRQ + int'(idx)] = 1'b1;
    return m;
  endfunction

  logic clrValid;
  assign clrValid = pendClr && (32'(pendIrq) < NUM_IRQ);

  // R3: an error pulse only follows an access
  p_err_cause_r3: assert property (@(posedge clk) disable iff (rst)
    regErr |-> $past(regWrEn || regRdEn));

  // R3: a bad access returns zero data
  p_err_zero_r3: assert property (@(posedge clk) disable iff (rst)
    regErr |-> (regRdData == 8'h00));

  // R2: read data carries no bits beyond the existing CPUs
  p_rd_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (regRdData & ~ALL8) == 8'h00);

  // R7: clear empties the interrupt on every CPU
  p_clear_all_r7: assert property (@(posedge clk) disable iff (rst)
    clrValid |=> ((cpuPending & colMask($past(pendIrq))) == '0));

  // R6 / R8: a pending bit rises only through a set request or a target write
  p_rise_cause_r6: assert property (@(posedge clk) disable iff (rst)
    ((cpuPending & ~$past(cpuPending)) != '0) |-> $past(pendSet || regWrEn));

  if (NUM_CPU > 1 && NUM_IRQ >= 32) begin : g_internal
    logic rdInternal;
    assign rdInternal = regRdEn && (regAddr >= BASE) && (regAddr < BASE + ADDR_W'(32));
    // R4: internal fields read back as all CPUs
    p_internal_all_r4: assert property (@(posedge clk) disable iff (rst)
      rdInternal |=> (regRdData == ALL8));
  end
endmodule

bind dist_target_router dist_target_router_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .PIRQ_W(PIRQ_W)
) u_chk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regRdData(regRdData), .regErr(regErr), .pendSet(pendSet), .pendClr(pendClr),
  .pendIrq(pendIrq), .cpuPending(cpuPending)
);

// File: tb/tb_dist_target_router.sv
module tb_dist_target_router;
  localparam int NI = 64;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [7:0]    regWrData = '0;
  logic          pendSet = 1'b0, pendClr = 1'b0;
  logic [5:0]    pendIrq = '0;
  logic [7:0]    regRdData, rdOne;
  logic          regErr, errOne;
  logic [NC*NI-1:0] cpuPending;
  logic [NI-1:0] pendOneVec;

  always #4 clk = ~clk; // 125 MHz

  dist_target_router #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .regErr(regErr),
    .pendSet(pendSet), .pendClr(pendClr), .pendIrq(pendIrq), .cpuPending(cpuPending));

  dist_target_router #(.NUM_IRQ(NI), .NUM_CPU(1)) dutOne (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(rdOne), .regErr(errOne),
    .pendSet(pendSet), .pendClr(pendClr), .pendIrq(pendIrq), .cpuPending(pendOneVec));

  typedef struct {
    string         tag;
    logic [NC*NI-1:0] pend;
    logic [NI-1:0] onePend;
    logic [7:0]    rd;
    logic          err;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  logic [NC-1:0] mTgt  [NI];
  logic [NC-1:0] mPend [NI];
  logic          mOne  [NI];

  task automatic step(input string tag, input logic wr, input logic rd,
                      input logic [11:0] addr, input logic [7:0] data,
                      input logic set, input logic clr, input logic [5:0] pirq);
    item_t it;
    int off;
    bit inWin;
    off   = int'(addr) - 2048;
    inWin = (addr >= 12'h800) && (off < NI);
    it.tag = tag;
    it.err = (wr || rd) && !inWin;
    it.rd  = 8'h00;
    if (rd && inWin) it.rd = (off < 32) ? 8'h0F : {4'h0, mTgt[off]};
    if (wr && inWin && off >= 32) begin
      if (mPend[off] != '0) mPend[off] = data[NC-1:0];
      mTgt[off] = data[NC-1:0];
    end
    if (clr) begin
      mPend[pirq] = '0;
      mOne[pirq]  = 1'b0;
    end else if (set) begin
      mPend[pirq] = (pirq < 32) ? 4'hF : mTgt[pirq];
      mOne[pirq]  = 1'b1;
    end
    for (int i = 0; i < NI; i++) begin
      it.onePend[i] = mOne[i];
      for (int c = 0; c < NC; c++) it.pend[c*NI + i] = mPend[i][c];
    end
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regAddr = addr; regWrData = data;
    pendSet = set; pendClr = clr; pendIrq = pirq;
    @(posedge clk);
    #1;
    regWrEn = 1'b0; regRdEn = 1'b0; pendSet = 1'b0; pendClr = 1'b0;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0, 6'd0);
  endtask
  task automatic wr(input string tag, input logic [11:0] a, input logic [7:0] d);
    step(tag, 1'b1, 1'b0, a, d, 1'b0, 1'b0, 6'd0);
  endtask
  task automatic rd(input string tag, input logic [11:0] a);
    step(tag, 1'b0, 1'b1, a, 8'h00, 1'b0, 1'b0, 6'd0);
  endtask
  task automatic req(input string tag, input logic s, input logic c, input logic [5:0] n);
    step(tag, 1'b0, 1'b0, 12'h000, 8'h00, s, c, n);
  endtask

  // monitor: compare queued expectations against outputs
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      nChecks++;
      if (cpuPending !== it.pend) begin
        nFails++;
        $display("FAIL %s pending act=%h exp=%h", it.tag, cpuPending, it.pend);
      end else if (pendOneVec !== it.onePend) begin
        nFails++;
        $display("FAIL %s single-cpu pending act=%h exp=%h", it.tag, pendOneVec, it.onePend);
      end else if (regRdData !== it.rd || regErr !== it.err) begin
        nFails++;
        $display("FAIL %s rd/err act=%h/%b exp=%h/%b", it.tag, regRdData, regErr, it.rd, it.err);
      end else if (rdOne !== 8'h00 || errOne !== it.err) begin
        nFails++;
        $display("FAIL %s single-cpu rd/err act=%h/%b exp=00/%b", it.tag, rdOne, errOne, it.err);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog act=timeout exp=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NI; i++) begin
      mTgt[i] = '0; mPend[i] = '0; mOne[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle("R1 reset pending");
    rd("R1 reset target", 12'h820);
    rd("R4 internal read", 12'h805);
    wr("R4 internal write", 12'h805, 8'h03);
    rd("R4 internal unchanged", 12'h805);
    wr("R2 write masked", 12'h820, 8'hFF);
    rd("R2 read masked", 12'h820);
    wr("R2 write 0x821", 12'h821, 8'h05);
    rd("R2 read 0x821 / R5 single reads zero", 12'h821);
    wr("R3 write past count", 12'h840, 8'h0F);
    rd("R3 read below window", 12'h7FF);
    rd("R3 read past count", 12'h840);
    wr("R3 write low offset", 12'h100, 8'h0F);
    req("R6 set shared 33", 1'b1, 1'b0, 6'd33);
    req("R6 set internal 3 / R5 cpu0", 1'b1, 1'b0, 6'd3);
    req("R6 set shared 34 empty mask", 1'b1, 1'b0, 6'd34);
    wr("R8 retarget pending 33", 12'h821, 8'h0A);
    wr("R8 retarget adds cpu0", 12'h821, 8'h0B);
    wr("R9 retarget idle 34", 12'h822, 8'h06);
    req("R9 set 34 new mask", 1'b1, 1'b0, 6'd34);
    req("R7 clear 33", 1'b0, 1'b1, 6'd33);
    req("R7 set+clear 34", 1'b1, 1'b1, 6'd34);
    req("R7 clear internal 3", 1'b0, 1'b1, 6'd3);
    step("R10 write+set 35", 1'b1, 1'b0, 12'h823, 8'h03, 1'b1, 1'b0, 6'd35);
    wr("R8 retarget to none 35", 12'h823, 8'h00);
    rd("R2 read 0x823", 12'h823);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule